// File: doc/BRIEF.md
# RV32I Instruction Decode Controller

This block turns one 32-bit base-integer RISC-V instruction per clock into the steering signals of a simple datapath. From each instruction it produces:

- the two source-register read addresses and the destination address;
- the destination write enable;
- the choice of ALU operand 1 (a register or the instruction address);
- the choice of ALU operand 2 (a register or the immediate);
- the sign-extended immediate for the instruction's format;
- the data-memory read and write strobes;
- the write-back selector.

The decoded word is captured in an output register. Each instruction therefore appears on the outputs one clock after it was presented, and a new instruction can be accepted every cycle.

LUI is carried out by the ALU as register 0 plus the immediate. For LUI the decoder forces the operand-1 read address to zero and routes operand 2 from the immediate. An opcode the block does not recognise leaves every write strobe and the memory read strobe low. The register file, ALU, memories, CSRs and trap handling sit outside the block.

Top module: `rv32_decode_ctrl`

## Requirements
- R1: rs1_addr_o carries instruction bits [19:15], rs2_addr_o carries bits [24:20] and rd_addr_o carries bits [11:7] for every instruction, except that LUI (opcode 7'b0110111) drives rs1_addr_o to 0.
- R2: op1_sel_o is 1 (instruction address) for AUIPC (7'b0010111), JAL (7'b1101111) and branches (7'b1100011), and 0 (register) for every other opcode.
- R3: op2_sel_o is 0 (register) for register-register ops (7'b0110011) and for unknown opcodes, and 1 (immediate) for loads, stores, OP-IMM, LUI, AUIPC, JAL, JALR and branches.
- R4: imm_o is the 32-bit sign-extended immediate of the opcode's format: I for OP-IMM (7'b0010011), loads (7'b0000011) and JALR (7'b1100111); S for stores (7'b0100011); B for branches; U for LUI and AUIPC; J for JAL. B and J immediates have bit 0 equal to 0. imm_o is 0 for register-register and unknown opcodes.
- R5: rd_we_o is 1 for OP, OP-IMM, LUI, AUIPC, loads, JAL and JALR, and 0 for stores and branches.
- R6: mem_re_o is 1 only for loads and mem_we_o is 1 only for stores, so the two are never high together.
- R7: wb_sel_o is 2'b00 (ALU result) for OP, OP-IMM, LUI and AUIPC, 2'b01 (memory data) for loads, and 2'b11 (PC+4) for JAL and JALR. The code 2'b10 never appears.
- R8: Any other opcode (for example FENCE, SYSTEM, all-zero or all-one words) gives rd_we_o, mem_we_o, mem_re_o, op1_sel_o, op2_sel_o and wb_sel_o all 0 and imm_o 0, while the address fields still follow R1.
- R9: While rst_ni is low every output is 0. Otherwise the outputs change only at a rising clock edge, and they then reflect the instruction present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 32 | Instruction word to decode |
| rs1_addr_o | output | 5 | Operand-1 register read address |
| rs2_addr_o | output | 5 | Operand-2 register read address |
| rd_addr_o | output | 5 | Destination register address |
| rd_we_o | output | 1 | Destination register write enable |
| op1_sel_o | output | 1 | ALU operand 1: 0 register, 1 instruction address |
| op2_sel_o | output | 1 | ALU operand 2: 0 register, 1 immediate |
| imm_o | output | 32 | Sign-extended immediate |
| mem_re_o | output | 1 | Data memory read strobe |
| mem_we_o | output | 1 | Data memory write strobe |
| wb_sel_o | output | 2 | Write-back source: 00 ALU, 01 memory, 11 PC+4 |

## Verification
Several corner cases are only reached through particular bit patterns, so the bench builds those words field by field from the encoding rules:

- immediates whose scattered fields hold the sign bit, such as the most negative J offset or a -2048 load offset;
- a LUI whose bits [19:15] are all ones, so that the forced zero on rs1 is visible.

Back-to-back instructions of different formats are issued with no idle cycles, so that a stale field from the previous word would show. A change of instr_i placed between two edges checks that the outputs hold their value until the next edge.

// File: rtl/dec_pkg.sv
package dec_pkg;
  localparam int unsigned XLEN  = 32;
  localparam int unsigned RAW   = 5;
  localparam int unsigned OPW   = 7;
  localparam int unsigned WBW   = 2;

  typedef enum logic [OPW-1:0] {
    OPC_LUI    = 7'b0110111,
    OPC_AUIPC  = 7'b0010111,
    OPC_JAL    = 7'b1101111,
    OPC_JALR   = 7'b1100111,
    OPC_BRANCH = 7'b1100011,
    OPC_LOAD   = 7'b0000011,
    OPC_STORE  = 7'b0100011,
    OPC_OPIMM  = 7'b0010011,
    OPC_OP     = 7'b0110011
  } opc_e;

  typedef enum logic [2:0] {
    FMT_NONE, FMT_I, FMT_S, FMT_B, FMT_U, FMT_J
  } fmt_e;

  typedef enum logic [WBW-1:0] {
    WB_ALU = 2'b00,
    WB_MEM = 2'b01,
    WB_PC4 = 2'b11
  } wb_e;

  typedef struct packed {
    logic rs1_zero;
    logic rd_we;
    logic op1_pc;
    logic op2_imm;
    logic mem_re;
    logic mem_we;
    wb_e  wb_sel;
    fmt_e fmt;
  } ctrl_t;

  typedef struct packed {
    logic [RAW-1:0]  rs1;
    logic [RAW-1:0]  rs2;
    logic [RAW-1:0]  rd;
    logic            rd_we;
    logic            op1_pc;
    logic            op2_imm;
    logic [XLEN-1:0] imm;
    logic            mem_re;
    logic            mem_we;
    logic [WBW-1:0]  wb_sel;
  } dec_t;
endpackage

// File: rtl/dec_ctrl_gen.sv
module dec_ctrl_gen
  import dec_pkg::*;
#(
  parameter int unsigned OP_W = OPW
) (
  input  logic [OP_W-1:0] opc_i,
  output ctrl_t           ctrl_o
);
  always_comb begin
    ctrl_o = '{rs1_zero: 1'b0, rd_we: 1'b0, op1_pc: 1'b0, op2_imm: 1'b0,
               mem_re: 1'b0, mem_we: 1'b0, wb_sel: WB_ALU, fmt: FMT_NONE};
    unique case (opc_i)
      OPC_LUI: begin
        ctrl_o.rs1_zero = 1'b1;
        ctrl_o.rd_we    = 1'b1;
        ctrl_o.op2_imm  = 1'b1;
        ctrl_o.fmt      = FMT_U;
      end
      OPC_AUIPC: begin
        ctrl_o.rd_we   = 1'b1;
        ctrl_o.op1_pc  = 1'b1;
        ctrl_o.op2_imm = 1'b1;
        ctrl_o.fmt     = FMT_U;
      end
      OPC_JAL: begin
        ctrl_o.rd_we   = 1'b1;
        ctrl_o.op1_pc  = 1'b1;
        ctrl_o.op2_imm = 1'b1;
        ctrl_o.wb_sel  = WB_PC4;
        ctrl_o.fmt     = FMT_J;
      end
      OPC_JALR: begin
        ctrl_o.rd_we   = 1'b1;
        ctrl_o.op2_imm = 1'b1;
        ctrl_o.wb_sel  = WB_PC4;
        ctrl_o.fmt     = FMT_I;
      end
      OPC_BRANCH: begin
        ctrl_o.op1_pc  = 1'b1;
        ctrl_o.op2_imm = 1'b1;
        ctrl_o.fmt     = FMT_B;
      end
      OPC_LOAD: begin
        ctrl_o.rd_we   = 1'b1;
        ctrl_o.op2_imm = 1'b1;
        ctrl_o.mem_re  = 1'b1;
        ctrl_o.wb_sel  = WB_MEM;
        ctrl_o.fmt     = FMT_I;
      end
      OPC_STORE: begin
        ctrl_o.op2_imm = 1'b1;
        ctrl_o.mem_we  = 1'b1;
        ctrl_o.fmt     = FMT_S;
      end
      OPC_OPIMM: begin
        ctrl_o.rd_we   = 1'b1;
        ctrl_o.op2_imm = 1'b1;
        ctrl_o.fmt     = FMT_I;
      end
      OPC_OP: begin
        ctrl_o.rd_we = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dec_imm_gen.sv
module dec_imm_gen
  import dec_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic [24:0]  hi_i,   // instruction bits [31:7]
  input  fmt_e         fmt_i,
  output logic [W-1:0] imm_o
);
  logic s;
  assign s = hi_i[24];

  always_comb begin
    unique case (fmt_i)
      FMT_I:   imm_o = {{(W-12){s}}, hi_i[24:13]};
      FMT_S:   imm_o = {{(W-12){s}}, hi_i[24:18], hi_i[4:0]};
      FMT_B:   imm_o = {{(W-12){s}}, hi_i[0], hi_i[23:18], hi_i[4:1], 1'b0};
      FMT_U:   imm_o = {{(W-32){s}}, hi_i[24:5], 12'b0};
      FMT_J:   imm_o = {{(W-20){s}}, hi_i[12:5], hi_i[13], hi_i[23:14], 1'b0};
      default: imm_o = '0;
    endcase
  end
endmodule

// File: rtl/rv32_decode_ctrl.sv
module rv32_decode_ctrl
  import dec_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [31:0]     instr_i,
  output logic [RAW-1:0]  rs1_addr_o,
  output logic [RAW-1:0]  rs2_addr_o,
  output logic [RAW-1:0]  rd_addr_o,
  output logic            rd_we_o,
  output logic            op1_sel_o,
  output logic            op2_sel_o,
  output logic [XLEN-1:0] imm_o,
  output logic            mem_re_o,
  output logic            mem_we_o,
  output logic [WBW-1:0]  wb_sel_o
);
  ctrl_t           ctrl;
  logic [XLEN-1:0] imm;
  dec_t            dec_d, dec_q;

  dec_ctrl_gen #(.OP_W(OPW)) i_ctrl (
    .opc_i  (instr_i[OPW-1:0]),
    .ctrl_o (ctrl)
  );

  dec_imm_gen #(.W(XLEN)) i_imm (
    .hi_i  (instr_i[31:7]),
    .fmt_i (ctrl.fmt),
    .imm_o (imm)
  );

  always_comb begin
    dec_d.rs1     = ctrl.rs1_zero ? '0 : instr_i[19:15];
    dec_d.rs2     = instr_i[24:20];
    dec_d.rd      = instr_i[11:7];
    dec_d.rd_we   = ctrl.rd_we;
    dec_d.op1_pc  = ctrl.op1_pc;
    dec_d.op2_imm = ctrl.op2_imm;
    dec_d.imm     = imm;
    dec_d.mem_re  = ctrl.mem_re;
    dec_d.mem_we  = ctrl.mem_we;
    dec_d.wb_sel  = ctrl.wb_sel;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dec_q <= '0;
    else         dec_q <= dec_d;
  end

  assign rs1_addr_o = dec_q.rs1;
  assign rs2_addr_o = dec_q.rs2;
  assign rd_addr_o  = dec_q.rd;
  assign rd_we_o    = dec_q.rd_we;
  assign op1_sel_o  = dec_q.op1_pc;
  assign op2_sel_o  = dec_q.op2_imm;
  assign imm_o      = dec_q.imm;
  assign mem_re_o   = dec_q.mem_re;
  assign mem_we_o   = dec_q.mem_we;
  assign wb_sel_o   = dec_q.wb_sel;
endmodule

// File: rtl/rv32_decode_chk.sv
module rv32_decode_chk
  import dec_pkg::*;
(
  input logic           clk_i,
  input logic           rst_ni,
  input logic [OPW-1:0] opc_i,
  input logic [RAW-1:0] rs1_addr_i,
  input logic           rd_we_i,
  input logic           op1_sel_i,
  input logic           mem_re_i,
  input logic           mem_we_i,
  input logic [WBW-1:0] wb_sel_i
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  function automatic logic known(input logic [OPW-1:0] o);
    return o inside {OPC_LUI, OPC_AUIPC, OPC_JAL, OPC_JALR, OPC_BRANCH,
                     OPC_LOAD, OPC_STORE, OPC_OPIMM, OPC_OP};
  endfunction

  // R6
  mem_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_re_i && mem_we_i));

  // R5
  store_no_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |-> !rd_we_i);

  // R7
  wb_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_sel_i != 2'b10) && ((wb_sel_i == 2'b01) == mem_re_i));

  // R1
  lui_rs1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(opc_i) == OPC_LUI) |-> rs1_addr_i == '0);

  // R2
  jal_ctrl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(opc_i) == OPC_JAL) |-> (op1_sel_i && wb_sel_i == 2'b11 && rd_we_i));

  // R8
  unknown_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !known($past(opc_i))) |-> (!rd_we_i && !mem_we_i && !mem_re_i));
endmodule

bind rv32_decode_ctrl rv32_decode_chk i_rv32_decode_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .opc_i      (instr_i[6:0]),
  .rs1_addr_i (rs1_addr_o),
  .rd_we_i    (rd_we_o),
  .op1_sel_i  (op1_sel_o),
  .mem_re_i   (mem_re_o),
  .mem_we_i   (mem_we_o),
  .wb_sel_i   (wb_sel_o)
);

// File: tb/test_rv32_decode_ctrl.sv
`timescale 1ns/1ps
module test_rv32_decode_ctrl;
  localparam int TCLK = 20;

  typedef struct {
    logic [4:0]  rs1, rs2, rd;
    logic        we, op1, op2;
    logic [31:0] imm;
    logic        re, mwe;
    logic [1:0]  wb;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr = 32'hffff_ffff;
  logic [4:0]  rs1_o, rs2_o, rd_o;
  logic        we_o, op1_o, op2_o, re_o, mwe_o;
  logic [31:0] imm_o;
  logic [1:0]  wb_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  exp_t q[$];

  always #(TCLK/2) clk = ~clk;

  rv32_decode_ctrl i_rv32_decode_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .instr_i(instr),
    .rs1_addr_o(rs1_o), .rs2_addr_o(rs2_o), .rd_addr_o(rd_o),
    .rd_we_o(we_o), .op1_sel_o(op1_o), .op2_sel_o(op2_o), .imm_o(imm_o),
    .mem_re_o(re_o), .mem_we_o(mwe_o), .wb_sel_o(wb_o)
  );

  localparam logic [6:0] LUI = 7'b0110111, AUIPC = 7'b0010111, JAL = 7'b1101111,
    JALR = 7'b1100111, BR = 7'b1100011, LD = 7'b0000011, ST = 7'b0100011,
    OPI = 7'b0010011, OPR = 7'b0110011;

  function automatic logic [31:0] enc_i(logic [11:0] im, logic [4:0] a, logic [2:0] f, logic [4:0] d, logic [6:0] o);
    return {im, a, f, d, o};
  endfunction
  function automatic logic [31:0] enc_s(logic [11:0] im, logic [4:0] b, logic [4:0] a, logic [2:0] f);
    return {im[11:5], b, a, f, im[4:0], ST};
  endfunction
  function automatic logic [31:0] enc_b(logic [12:0] im, logic [4:0] b, logic [4:0] a, logic [2:0] f);
    return {im[12], im[10:5], b, a, f, im[4:1], im[11], BR};
  endfunction
  function automatic logic [31:0] enc_u(logic [31:0] im, logic [4:0] d, logic [6:0] o);
    return {im[31:12], d, o};
  endfunction
  function automatic logic [31:0] enc_j(logic [20:0] im, logic [4:0] d);
    return {im[20], im[10:1], im[11], im[19:12], d, JAL};
  endfunction

  task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (%s): actual %h expected %h", req, tag, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] ins, input logic [4:0] rs1, input logic we, op1, op2,
                      input logic [31:0] imm, input logic re, mwe, input logic [1:0] wb, input string tag);
    exp_t e;
    e.rs1 = rs1; e.rs2 = ins[24:20]; e.rd = ins[11:7];
    e.we = we; e.op1 = op1; e.op2 = op2; e.imm = imm;
    e.re = re; e.mwe = mwe; e.wb = wb; e.tag = tag;
    @(negedge clk);
    instr = ins;
    q.push_back(e);
  endtask

  // monitor: item pushed before an edge is compared just after that edge
  always @(posedge clk) begin
    if (rst_n && q.size() > 0) begin
      exp_t e;
      #5;
      e = q.pop_front();
      cmp("R1 rs1", {27'b0, rs1_o}, {27'b0, e.rs1}, e.tag);
      cmp("R1 rs2", {27'b0, rs2_o}, {27'b0, e.rs2}, e.tag);
      cmp("R1 rd",  {27'b0, rd_o},  {27'b0, e.rd},  e.tag);
      cmp("R2 op1", {31'b0, op1_o}, {31'b0, e.op1}, e.tag);
      cmp("R3 op2", {31'b0, op2_o}, {31'b0, e.op2}, e.tag);
      cmp("R4 imm", imm_o, e.imm, e.tag);
      cmp("R5 rd_we", {31'b0, we_o}, {31'b0, e.we}, e.tag);
      cmp("R6 mem_re", {31'b0, re_o}, {31'b0, e.re}, e.tag);
      cmp("R6 mem_we", {31'b0, mwe_o}, {31'b0, e.mwe}, e.tag);
      cmp("R7 wb_sel", {30'b0, wb_o}, {30'b0, e.wb}, e.tag);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(TCLK * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R9 reset state
    #(TCLK * 3 + 3);
    cmp("R9 reset", {rs1_o, rs2_o, rd_o, we_o, op1_o, op2_o, re_o, mwe_o, wb_o}, 32'h0, "reset");
    cmp("R9 reset imm", imm_o, 32'h0, "reset");
    @(negedge clk);
    rst_n = 1'b1;

    send(32'h00a02223, 5'd0, 0, 0, 1, 32'd4, 0, 1, 2'b00, "R6 store");
    send(32'h000022b7, 5'd0, 1, 0, 1, 32'h0000_2000, 0, 0, 2'b00, "R1 lui");
    send(32'h000fa2b7, 5'd0, 1, 0, 1, 32'h000f_a000, 0, 0, 2'b00, "R1 lui rs1 field 31");
    send(32'h002081b3, 5'd1, 1, 0, 0, 32'h0, 0, 0, 2'b00, "R3 add");
    send(32'h00208163, 5'd1, 0, 1, 1, 32'd2, 0, 0, 2'b00, "R2 beq");
    send(enc_b(-13'sd8, 5'd5, 5'd6, 3'd1), 5'd6, 0, 1, 1, 32'hffff_fff8, 0, 0, 2'b00, "R4 branch neg");
    send(32'hfff00093, 5'd0, 1, 0, 1, 32'hffff_ffff, 0, 0, 2'b00, "R4 addi -1");
    send(enc_i(12'h800, 5'd8, 3'd2, 5'd7, LD), 5'd8, 1, 0, 1, 32'hffff_f800, 1, 0, 2'b01, "R6 R7 load");
    send(enc_s(-12'sd4, 5'd2, 5'd1, 3'd2), 5'd1, 0, 0, 1, 32'hffff_fffc, 0, 1, 2'b00, "R4 store neg");
    send(enc_j(21'h100000, 5'd1), 5'd0, 1, 1, 1, 32'hfff0_0000, 0, 0, 2'b11, "R7 jal min");
    send(enc_j(21'h0007fe, 5'd31), 5'd0, 1, 1, 1, 32'h0000_07fe, 0, 0, 2'b11, "R4 jal pos");
    send(enc_i(12'h010, 5'd5, 3'd0, 5'd1, JALR), 5'd5, 1, 0, 1, 32'h10, 0, 0, 2'b11, "R7 jalr");
    send(enc_u(32'h8000_0000, 5'd10, AUIPC), 5'd0, 1, 1, 1, 32'h8000_0000, 0, 0, 2'b00, "R2 auipc");
    send(enc_i(12'h7ff, 5'd3, 3'd7, 5'd4, OPI), 5'd3, 1, 0, 1, 32'h0000_07ff, 0, 0, 2'b00, "R5 andi");
    // R8 unknown opcodes
    send(32'h0ff0000f, 5'd0, 0, 0, 0, 32'h0, 0, 0, 2'b00, "R8 fence");
    send(32'h00000073, 5'd0, 0, 0, 0, 32'h0, 0, 0, 2'b00, "R8 system");
    send(32'hffffffff, 5'd31, 0, 0, 0, 32'h0, 0, 0, 2'b00, "R8 all ones");
    send(32'h00000000, 5'd0, 0, 0, 0, 32'h0, 0, 0, 2'b00, "R8 all zero");
    send(enc_u(32'h1234_5000, 5'd9, LUI), 5'd0, 1, 0, 1, 32'h1234_5000, 0, 0, 2'b00, "R5 lui after unknown");

    // R9: outputs hold between edges
    @(posedge clk); #6;
    @(negedge clk);
    instr = enc_s(12'h0, 5'd3, 5'd4, 3'd2);
    #5;
    cmp("R9 hold we", {31'b0, we_o}, 32'd1, "hold");
    cmp("R9 hold imm", imm_o, 32'h1234_5000, "hold");
    cmp("R9 hold mem_we", {31'b0, mwe_o}, 32'd0, "hold");
    @(posedge clk); #5;
    cmp("R9 update mem_we", {31'b0, mwe_o}, 32'd1, "hold");

    // R9: asynchronous reset clears outputs mid-run
    #2 rst_n = 1'b0;
    #1;
    cmp("R9 async reset", {rs1_o, rs2_o, rd_o, we_o, op1_o, op2_o, re_o, mwe_o, wb_o}, 32'h0, "mid reset");
    @(negedge clk);
    rst_n = 1'b1;

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule